// File: doc/BRIEF.md
# XOR-Delta Sparse Vector Compressor

This unit decides where an older intermediate bitvector goes before it is evicted from the prefix buffer. Vector A, the older one, is either kept on chip as the difference C = A XOR B against the newest vector B, or sent off chip unchanged. The unit reads A and B one word at a time through a read port with one cycle of latency, in two passes. The first pass counts the nonzero words of C. Between the passes the unit makes the admission decision. The second pass then either packs the nonzero words of C, each with its word index, into a scratchpad, or streams the raw words of A out on the spill port.

A stored entry is recorded in an address table under A's off-chip address. A later decompress request names that address. It reads the current B through the same port and rebuilds A word by word. A word that has a stored difference comes out as B XOR that difference. Every other word comes out as B unchanged.

Top module: `xdp_compressor`

## Requirements
- R1: The difference is formed per word as C[i] = A[i] XOR B[i]. Decompression returns B[i] XOR C[i] for every stored index.
- R2: Only nonzero words of C take scratchpad slots. The retained count k is the number of indices i with C[i] != 0.
- R3: If k*(WORD_W+IDX_W)*100 > THR_PCT*VEC_WORDS*WORD_W, the vector is rejected. With the defaults (32-bit words, 16 words, 4-bit index, THR_PCT=50), k=7 is admitted and k=8 is rejected. On a reject, spill_valid_o carries all VEC_WORDS raw words of A in index order 0 to VEC_WORDS-1, and done_ok_o is 0.
- R4: If the scratchpad occupancy plus k exceeds SCR_DEPTH, the vector is rejected and spilled as in R3. Exactly filling the scratchpad is allowed. Occupancy grows by k only on an admission.
- R5: Once TBL_DEPTH entries are recorded, every further compress is rejected and spilled, even with k=0.
- R6: An admitted vector produces no spill beats. It finishes with done_ok_o=1, and its address becomes findable by decompress.
- R7: A decompress that hits emits VEC_WORDS beats on out_valid_o with out_idx_o running 0 to VEC_WORDS-1. Each beat carries B[i] XOR C[i] if index i was stored, and B[i] otherwise. It then finishes with done_ok_o=1.
- R8: A decompress of an address that is not in the table emits no out beats and finishes with done_ok_o=0.
- R9: When one address was recorded more than once, decompress uses the newest entry.
- R10: A start is taken only while busy_o is low, and a start seen while busy is ignored. A compress start wins over a decompress start in the same cycle. done_o is a single-cycle pulse that ends every operation.
- R11: After reset the unit is idle with no outputs active. The table is empty, so any decompress misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_start_i | input | 1 | Start a compress of the current A/B pair |
| cmp_addr_i | input | ADDR_W | Off-chip address of A for the compress |
| dec_start_i | input | 1 | Start a decompress |
| dec_addr_i | input | ADDR_W | Address to look up for the decompress |
| rd_en_o | output | 1 | Word read request to the prefix buffer |
| rd_idx_o | output | IDX_W | Word index of the read |
| a_word_i | input | WORD_W | Word of A, valid the cycle after rd_en_o |
| b_word_i | input | WORD_W | Word of B, valid the cycle after rd_en_o |
| spill_valid_o | output | 1 | Raw A word for off-chip write |
| spill_idx_o | output | IDX_W | Index of the spilled word |
| spill_word_o | output | WORD_W | Spilled word |
| out_valid_o | output | 1 | Rebuilt word of A |
| out_idx_o | output | IDX_W | Index of the rebuilt word |
| out_word_o | output | WORD_W | Rebuilt word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (pulse) |
| done_ok_o | output | 1 | With done_o: kept on chip (compress) or hit (decompress) |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- Only nonzero difference words are written to the scratchpad.
- The scratchpad and the table never overflow.
- Spill and output beats never overlap, and each stream steps through indices one at a time.
- done_o is a single pulse, and reads happen only while busy.

The admission decision needs the bench's scenarios to show it. These include the 7/8 word threshold edge, the exact fill of the scratchpad, the full table, and the newest-entry rule on a repeated address. The scenarios also show that the rebuilt vector equals A even when B has changed.

// File: rtl/xdp_pkg.sv
package xdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DECIDE,
    ST_WRITE,
    ST_DEC
  } xdp_state_e;
endpackage

// File: rtl/xdp_delta_stage.sv
module xdp_delta_stage #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              vld_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o,
  output logic [WORD_W-1:0] x_o,
  output logic              nz_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      idx_o <= '0;
      a_o   <= '0;
      b_o   <= '0;
      x_o   <= '0;
      nz_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        idx_o <= idx_i;
        a_o   <= a_i;
        b_o   <= b_i;
        x_o   <= a_i ^ b_i;
        nz_o  <= |(a_i ^ b_i);
      end
    end
  end
endmodule

// File: rtl/xdp_scratch.sv
module xdp_scratch #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4,
  parameter int DEPTH  = 32,
  parameter int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [PTR_W-1:0]  occ_o
);
  localparam int SAW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  mem_idx  [DEPTH];
  logic [WORD_W-1:0] mem_word [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
    end else if (wr_en_i) begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_idx[wr_ptr_q[SAW-1:0]]  <= wr_idx_i;
      mem_word[wr_ptr_q[SAW-1:0]] <= wr_word_i;
    end
  end

  always_comb begin
    rd_idx_o  = '0;
    rd_word_o = '0;
    if (rd_ptr_i < PTR_W'(DEPTH)) begin
      rd_idx_o  = mem_idx[rd_ptr_i[SAW-1:0]];
      rd_word_o = mem_word[rd_ptr_i[SAW-1:0]];
    end
  end

  assign occ_o = wr_ptr_q;

  AST_SCR_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_ptr_q < PTR_W'(DEPTH))); // R4
  AST_SCR_NONZERO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_word_i != '0)); // R2
endmodule

// File: rtl/xdp_addr_table.sv
module xdp_addr_table #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 6,
  parameter int CNT_W  = 5,
  parameter int SLOTS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PTR_W-1:0]  wr_base_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [PTR_W-1:0]  lk_base_o,
  output logic [CNT_W-1:0]  lk_cnt_o,
  output logic              full_o
);
  localparam int NW = $clog2(SLOTS + 1);

  logic [NW-1:0]    used_q;
  logic [SLOTS-1:0] hit_vec;
  logic [PTR_W-1:0] slot_base [SLOTS];
  logic [CNT_W-1:0] slot_cnt  [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= '0;
    else if (wr_en_i && !full_o) used_q <= used_q + 1'b1;
  end

  assign full_o = (used_q == NW'(SLOTS));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              vld_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PTR_W-1:0]  base_q;
    logic [CNT_W-1:0]  cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        addr_q <= '0;
        base_q <= '0;
        cnt_q  <= '0;
      end else if (wr_en_i && (used_q == NW'(s))) begin
        vld_q  <= 1'b1;
        addr_q <= wr_addr_i;
        base_q <= wr_base_i;
        cnt_q  <= wr_cnt_i;
      end
    end
    assign hit_vec[s]   = vld_q && (addr_q == lk_addr_i);
    assign slot_base[s] = base_q;
    assign slot_cnt[s]  = cnt_q;
  end

  // highest slot is the newest entry
  always_comb begin
    lk_hit_o  = 1'b0;
    lk_base_o = '0;
    lk_cnt_o  = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (hit_vec[s]) begin
        lk_hit_o  = 1'b1;
        lk_base_o = slot_base[s];
        lk_cnt_o  = slot_cnt[s];
      end
    end
  end

  AST_TBL_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o); // R5
endmodule

// File: rtl/xdp_compressor.sv
module xdp_compressor
  import xdp_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int VEC_WORDS = 16,
  parameter int SCR_DEPTH = 32,
  parameter int TBL_DEPTH = 8,
  parameter int ADDR_W    = 32,
  parameter int THR_PCT   = 50,
  localparam int IDX_W    = $clog2(VEC_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_start_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic              dec_start_i,
  input  logic [ADDR_W-1:0] dec_addr_i,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [WORD_W-1:0] a_word_i,
  input  logic [WORD_W-1:0] b_word_i,
  output logic              spill_valid_o,
  output logic [IDX_W-1:0]  spill_idx_o,
  output logic [WORD_W-1:0] spill_word_o,
  output logic              out_valid_o,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic [WORD_W-1:0] out_word_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_ok_o
);
  localparam int CNT_W      = $clog2(VEC_WORDS + 1);
  localparam int PTR_W      = $clog2(SCR_DEPTH + 1);
  localparam int ENTRY_BITS = WORD_W + IDX_W;
  localparam int RAW_BITS   = VEC_WORDS * WORD_W;
  localparam int MAX_KEEP   = (THR_PCT * RAW_BITS) / (ENTRY_BITS * 100);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_WORDS - 1);

  xdp_state_e        state_q;
  logic              iss_act_q;
  logic [IDX_W-1:0]  iss_idx_q;
  logic              src_vld_q;
  logic [IDX_W-1:0]  src_idx_q;
  logic [CNT_W-1:0]  nz_cnt_q;
  logic              accept_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PTR_W-1:0]  base_q, rptr_q, end_q;
  logic              done_q, ok_q;

  logic              st_vld, st_nz;
  logic [IDX_W-1:0]  st_idx;
  logic [WORD_W-1:0] st_a, st_b, st_x;
  logic              last_ret;

  logic              scr_wr_en;
  logic [IDX_W-1:0]  scr_rd_idx;
  logic [WORD_W-1:0] scr_rd_word;
  logic [PTR_W-1:0]  occ;

  logic              tbl_wr_en, lk_hit, tbl_full;
  logic [PTR_W-1:0]  lk_base;
  logic [CNT_W-1:0]  lk_cnt;

  logic              thr_exc, cap_exc, dec_match;

  assign rd_en_o  = iss_act_q;
  assign rd_idx_o = iss_idx_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign done_ok_o = ok_q;

  xdp_delta_stage #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_delta (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (src_vld_q),
    .idx_i (src_idx_q),
    .a_i   (a_word_i),
    .b_i   (b_word_i),
    .vld_o (st_vld),
    .idx_o (st_idx),
    .a_o   (st_a),
    .b_o   (st_b),
    .x_o   (st_x),
    .nz_o  (st_nz)
  );

  assign last_ret = st_vld && (st_idx == LAST_IDX);

  assign thr_exc = int'(nz_cnt_q) > MAX_KEEP;
  assign cap_exc = (int'(occ) + int'(nz_cnt_q)) > SCR_DEPTH;

  assign scr_wr_en = (state_q == ST_WRITE) && st_vld && st_nz && accept_q;
  assign tbl_wr_en = (state_q == ST_WRITE) && last_ret && accept_q;

  xdp_scratch #(.WORD_W(WORD_W), .IDX_W(IDX_W), .DEPTH(SCR_DEPTH), .PTR_W(PTR_W)) i_scratch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (scr_wr_en),
    .wr_idx_i (st_idx),
    .wr_word_i(st_x),
    .rd_ptr_i (rptr_q),
    .rd_idx_o (scr_rd_idx),
    .rd_word_o(scr_rd_word),
    .occ_o    (occ)
  );

  xdp_addr_table #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .SLOTS(TBL_DEPTH)) i_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (tbl_wr_en),
    .wr_addr_i(addr_q),
    .wr_base_i(base_q),
    .wr_cnt_i (nz_cnt_q),
    .lk_addr_i(dec_addr_i),
    .lk_hit_o (lk_hit),
    .lk_base_o(lk_base),
    .lk_cnt_o (lk_cnt),
    .full_o   (tbl_full)
  );

  assign dec_match = (state_q == ST_DEC) && st_vld && (rptr_q < end_q) && (scr_rd_idx == st_idx);

  assign spill_valid_o = (state_q == ST_WRITE) && st_vld && !accept_q;
  assign spill_idx_o   = st_idx;
  assign spill_word_o  = st_a;
  assign out_valid_o   = (state_q == ST_DEC) && st_vld;
  assign out_idx_o     = st_idx;
  assign out_word_o    = st_b ^ (dec_match ? scr_rd_word : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      iss_act_q <= 1'b0;
      iss_idx_q <= '0;
      src_vld_q <= 1'b0;
      src_idx_q <= '0;
      nz_cnt_q  <= '0;
      accept_q  <= 1'b0;
      addr_q    <= '0;
      base_q    <= '0;
      rptr_q    <= '0;
      end_q     <= '0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      src_vld_q <= iss_act_q;
      src_idx_q <= iss_idx_q;
      if (iss_act_q) begin
        if (iss_idx_q == LAST_IDX) iss_act_q <= 1'b0;
        else iss_idx_q <= iss_idx_q + 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (cmp_start_i) begin
            addr_q    <= cmp_addr_i;
            nz_cnt_q  <= '0;
            iss_act_q <= 1'b1;
            iss_idx_q <= '0;
            state_q   <= ST_SCAN;
          end else if (dec_start_i) begin
            if (lk_hit) begin
              rptr_q    <= lk_base;
              end_q     <= lk_base + PTR_W'(lk_cnt);
              iss_act_q <= 1'b1;
              iss_idx_q <= '0;
              state_q   <= ST_DEC;
            end else begin
              done_q <= 1'b1;
              ok_q   <= 1'b0;
            end
          end
        end
        ST_SCAN: begin
          if (st_vld && st_nz) nz_cnt_q <= nz_cnt_q + 1'b1;
          if (last_ret) state_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          accept_q  <= !(thr_exc || cap_exc || tbl_full);
          base_q    <= occ;
          iss_act_q <= 1'b1;
          iss_idx_q <= '0;
          state_q   <= ST_WRITE;
        end
        ST_WRITE: begin
          if (last_ret) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            ok_q    <= accept_q;
          end
        end
        ST_DEC: begin
          if (dec_match) rptr_q <= rptr_q + 1'b1;
          if (last_ret) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            ok_q    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SPILL_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spill_valid_o && out_valid_o)); // R6
  AST_SPILL_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_valid_o && $past(spill_valid_o)) |-> (spill_idx_o == $past(spill_idx_o) + 1'b1)); // R3
  AST_OUT_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o)) |-> (out_idx_o == $past(out_idx_o) + 1'b1)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_READ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> busy_o); // R10
  AST_NO_STORE_ON_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_valid_o |-> !scr_wr_en); // R3
endmodule

// File: tb/test_xdp_compressor.sv
module test_xdp_compressor;
  localparam int N   = 16;
  localparam int W   = 32;
  localparam int SCR = 32;
  localparam int TBL = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmp_start_i = 1'b0;
  logic [31:0]   cmp_addr_i = '0;
  logic          dec_start_i = 1'b0;
  logic [31:0]   dec_addr_i = '0;
  logic          rd_en_o;
  logic [3:0]    rd_idx_o;
  logic [W-1:0]  a_word_i = '0;
  logic [W-1:0]  b_word_i = '0;
  logic          spill_valid_o;
  logic [3:0]    spill_idx_o;
  logic [W-1:0]  spill_word_o;
  logic          out_valid_o;
  logic [3:0]    out_idx_o;
  logic [W-1:0]  out_word_o;
  logic          busy_o, done_o, done_ok_o;

  xdp_compressor i_xdp_compressor (.*);

  always #10 clk_i = ~clk_i; // 50 MHz

  logic [W-1:0] mem_a [N];
  logic [W-1:0] mem_b [N];
  logic [W-1:0] cur_c [N];

  always @(posedge clk_i) begin
    if (rd_en_o) begin
      a_word_i <= mem_a[rd_idx_o];
      b_word_i <= mem_b[rd_idx_o];
    end
  end

  int n_tests = 0;
  int n_fail  = 0;

  int           exp_sp_idx[$];
  logic [W-1:0] exp_sp_word[$];
  int           exp_out_idx[$];
  logic [W-1:0] exp_out_word[$];

  int           mdl_n = 0;
  int           mdl_occ = 0;
  logic [31:0]  mdl_addr [TBL];
  logic [W-1:0] mdl_c [TBL][N];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of streamed beats against the model queues
  always @(negedge clk_i) begin
    if (rst_ni && spill_valid_o) begin
      if (exp_sp_idx.size() == 0) check(0, "R6", "unexpected spill beat", spill_idx_o, 0);
      else begin
        check(spill_idx_o == 4'(exp_sp_idx[0]), "R3", "spill index", spill_idx_o, exp_sp_idx[0]);
        check(spill_word_o == exp_sp_word[0], "R3", "spill word", spill_word_o, exp_sp_word[0]);
        void'(exp_sp_idx.pop_front());
        void'(exp_sp_word.pop_front());
      end
    end
    if (rst_ni && out_valid_o) begin
      if (exp_out_idx.size() == 0) check(0, "R8", "unexpected out beat", out_idx_o, 0);
      else begin
        check(out_idx_o == 4'(exp_out_idx[0]), "R7", "out index", out_idx_o, exp_out_idx[0]);
        check(out_word_o == exp_out_word[0], "R1", "rebuilt word", out_word_o, exp_out_word[0]);
        void'(exp_out_idx.pop_front());
        void'(exp_out_word.pop_front());
      end
    end
  end

  // k nonzero difference words at distinct positions (i*5+off)%16
  task automatic build(int k, int off);
    for (int i = 0; i < N; i++) begin
      mem_b[i] = $urandom();
      cur_c[i] = '0;
    end
    for (int i = 0; i < k; i++) cur_c[(i * 5 + off) % N] = $urandom() | 32'h1;
    for (int i = 0; i < N; i++) mem_a[i] = mem_b[i] ^ cur_c[i];
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk_i);
      cmp_start_i = 1'b0;
      dec_start_i = 1'b0;
      if (done_o) begin got = 1; break; end
    end
  endtask

  task automatic compress(logic [31:0] addr, int k, string req);
    bit acc, got;
    int nz = 0;
    for (int i = 0; i < N; i++) if (cur_c[i] != 0) nz++;
    acc = (nz * 36 * 100 <= 50 * N * W) && (mdl_occ + nz <= SCR) && (mdl_n < TBL);
    if (!acc) for (int i = 0; i < N; i++) begin
      exp_sp_idx.push_back(i);
      exp_sp_word.push_back(mem_a[i]);
    end
    @(negedge clk_i);
    cmp_addr_i  = addr;
    cmp_start_i = 1'b1;
    wait_done(got);
    check(got, req, "compress done seen", got, 1);
    check(done_ok_o == acc, req, "admission decision", done_ok_o, acc);
    check(exp_sp_idx.size() == 0, req, "spill beats missing", exp_sp_idx.size(), 0);
    if (acc) begin
      mdl_addr[mdl_n] = addr;
      for (int i = 0; i < N; i++) mdl_c[mdl_n][i] = cur_c[i];
      mdl_n++;
      mdl_occ += nz;
    end
  endtask

  task automatic decompress(logic [31:0] addr, string req);
    bit got;
    int slot = -1;
    for (int i = 0; i < N; i++) mem_b[i] = $urandom();
    for (int s = 0; s < mdl_n; s++) if (mdl_addr[s] == addr) slot = s;
    if (slot >= 0) for (int i = 0; i < N; i++) begin
      exp_out_idx.push_back(i);
      exp_out_word.push_back(mem_b[i] ^ mdl_c[slot][i]);
    end
    @(negedge clk_i);
    dec_addr_i  = addr;
    dec_start_i = 1'b1;
    wait_done(got);
    check(got, req, "decompress done seen", got, 1);
    check(done_ok_o == (slot >= 0), req, "lookup hit", done_ok_o, slot >= 0);
    check(exp_out_idx.size() == 0, req, "out beats missing", exp_out_idx.size(), 0);
  endtask

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    for (int i = 0; i < N; i++) begin mem_a[i] = '0; mem_b[i] = '0; cur_c[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    check(!busy_o && !done_o && !rd_en_o && !spill_valid_o && !out_valid_o, "R11",
          "idle after reset", {busy_o, done_o, rd_en_o}, 0);
    decompress(32'h100, "R11");            // empty table misses (R8)

    build(3, 2);  compress(32'h10, 3, "R6");
    decompress(32'h10, "R7");              // rebuilt with a fresh B (R1)
    build(8, 1);  compress(32'h99, 8, "R3"); // k=8 over ratio
    build(7, 0);  compress(32'h20, 7, "R3"); // k=7 at ratio edge, admitted
    decompress(32'h20, "R7");
    build(7, 3);  compress(32'h30, 7, "R6");
    build(7, 6);  compress(32'h40, 7, "R6");
    build(7, 11); compress(32'h50, 7, "R6"); // occupancy 31
    build(2, 4);  compress(32'h60, 2, "R4"); // 33 > 32 rejected
    build(1, 15); compress(32'h60, 1, "R4"); // exactly full, admitted
    decompress(32'h50, "R7");
    decompress(32'h60, "R2");
    build(0, 0);  compress(32'h10, 0, "R9"); // duplicate address, k=0
    decompress(32'h10, "R9");              // newest entry: plain B
    decompress(32'h30, "R7");
    build(0, 0);  compress(32'h70, 0, "R6"); // table now full
    build(0, 0);  compress(32'h80, 0, "R5"); // rejected by full table
    decompress(32'h80, "R8");

    // R10: simultaneous starts -> compress wins; start while busy ignored
    build(2, 5);
    for (int i = 0; i < N; i++) begin
      exp_sp_idx.push_back(i);
      exp_sp_word.push_back(mem_a[i]);
    end
    @(negedge clk_i);
    cmp_addr_i = 32'h90; cmp_start_i = 1'b1;
    dec_addr_i = 32'h20; dec_start_i = 1'b1;
    @(negedge clk_i);
    cmp_start_i = 1'b0; dec_start_i = 1'b0;
    check(busy_o, "R10", "busy after start", busy_o, 1);
    repeat (4) @(negedge clk_i);
    dec_addr_i = 32'h20; dec_start_i = 1'b1;
    wait_done(got);
    check(got && !done_ok_o, "R10", "compress won and spilled", done_ok_o, 0);
    check(exp_sp_idx.size() == 0, "R10", "spill beats missing", exp_sp_idx.size(), 0);
    for (int t = 0; t < 40; t++) begin
      @(negedge clk_i);
      if (done_o || busy_o) begin
        check(0, "R10", "ignored start ran", {done_o, busy_o}, 0);
        break;
      end
    end
    check(!busy_o, "R10", "idle after ignored start", busy_o, 0);
    decompress(32'h20, "R7");              // entry intact after all the above

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule